// File: doc/BRIEF.md
# Zero-Cross Gated Gain Updater

This block sits between a gain register and a gain stage. A new gain code is offered on a request strobe. With zero-cross gating off, the code reaches the gain output on the next clock edge. With gating on, the code is parked and applied only when the signal passing through the gain stage is close to zero, so the step in gain does not cause an audible click. If no crossing arrives, a free-running timeout forces the parked code through. The timeout can be switched off, and the parked code then waits for a crossing with no limit.

Zero crossings are found from the signed sample stream. A crossing is either a change of sign between two consecutive valid samples or a single sample whose magnitude is below a small threshold. The controller is a two-state machine. In `ST_IDLE` no code is parked. In `ST_WAIT` a code is held and `pending` is high. The named transitions are:
- `T_DIRECT` (IDLE→IDLE, request with gating off)
- `T_ARM` (IDLE→WAIT, request with gating on)
- `T_REARM` (WAIT→WAIT, a newer gated request replaces the parked code and restarts the timeout)
- `T_BYPASS` (WAIT→IDLE, gating switched off)
- `T_ZC` (WAIT→IDLE on a crossing)
- `T_TIMEOUT` (WAIT→IDLE when the count hits its top)

Top module: `zc_gain_updater`

## Requirements
- R1: After reset, `gain_out` is all ones and `pending` is low.
- R2: In ST_IDLE, a request with `zc_en` low copies `req_gain` to `gain_out` on the next clock edge. `pending` stays low.
- R3: In ST_IDLE, a request with `zc_en` high leaves `gain_out` unchanged and raises `pending` on the next edge. `gain_out` then holds until a crossing, a timeout, a bypass or a newer request ends the wait.
- R4: While waiting, a crossing applies the parked code and drops `pending` on the next edge. A crossing is a valid sample whose sign bit (MSB, two's complement) differs from the previous valid sample, or a valid sample s with -NEAR_THRESH < s < NEAR_THRESH (default 4). The first valid sample after reset counts only through the magnitude test.
- R5: While waiting with `timeout_dis` low, the counter is 0 after the arming edge and counts up by one per edge. When it equals 2^TIMEOUT_W-1 (131071 by default), the parked code is applied on that cycle's edge. With no crossing, this is 2^TIMEOUT_W edges after the arming edge.
- R6: While `timeout_dis` is high, the counter holds its value and no forced update happens. A parked code waits for a crossing.
- R7: A gated request during ST_WAIT replaces the parked code and resets the counter to 0. A crossing in that same cycle is ignored.
- R8: In ST_WAIT, if `zc_en` is low, the next edge applies `req_gain` when a request is present, and the parked code otherwise. The machine returns to ST_IDLE.
- R9: A crossing in the same cycle as an arming request does not apply that request.
- R10: A sample with `sample_valid` low is never a crossing and does not become the previous sample for the sign test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Gain request strobe |
| req_gain | input | GAIN_W | Requested gain code |
| zc_en | input | 1 | Zero-cross gating enable |
| timeout_dis | input | 1 | Disable forced update by timeout |
| sample_valid | input | 1 | Sample qualifier |
| sample | input | SAMPLE_W | Signed sample at the gain stage |
| gain_out | output | GAIN_W | Applied gain code |
| pending | output | 1 | A gated code is parked |

## Verification
The directed patterns are chosen to separate the three ways a wait can end:
- A sign flip between two large samples.
- A lone near-zero sample.
- Silence up to exactly the timeout edge, checked one cycle early as well as on the edge itself.

Further directed patterns cover the cases where priority matters:
- A replacing request during a wait, which shows the counter restarts rather than continues.
- Disabling the timeout, which shows the count freezes.
- Invalid samples of opposite sign, which must not count as crossings.

Random stimulus then mixes all inputs, with samples biased to long same-sign runs, so that crossings, timeouts and rearms interleave in orders the directed cases do not reach.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } zcg_state_e;
endpackage

// File: rtl/zcg_crossing_detect.sv
module zcg_crossing_detect #(
    parameter int SAMPLE_W    = 16,
    parameter int NEAR_THRESH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       zc_hit
);
    localparam logic signed [SAMPLE_W-1:0] THR_P = SAMPLE_W'(NEAR_THRESH);
    localparam logic signed [SAMPLE_W-1:0] THR_N = -THR_P;

    logic prev_sign;
    logic prev_seen;
    logic near_zero;
    logic sign_flip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sign <= 1'b0;
            prev_seen <= 1'b0;
        end else if (sample_valid) begin
            prev_sign <= sample[SAMPLE_W-1];
            prev_seen <= 1'b1;
        end
    end

    always_comb begin
        near_zero = (sample > THR_N) && (sample < THR_P);
        sign_flip = prev_seen && (prev_sign != sample[SAMPLE_W-1]);
        zc_hit    = sample_valid && (near_zero || sign_flip);
    end

    // R4: an exact zero sample is always a crossing
    assert_zero_is_crossing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample == '0) |-> zc_hit);

    // R10: invalid samples never signal a crossing
    assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> !zc_hit);
endmodule

// File: rtl/zcg_timeout.sv
module zcg_timeout #(
    parameter int TIMEOUT_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic fire
);
    localparam logic [TIMEOUT_W-1:0] TOP = {TIMEOUT_W{1'b1}};

    logic [TIMEOUT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (run && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    assign fire = run && (count == TOP);

    // R6: with the counter not running and not cleared, the count holds
    assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(count));

    // R5: a running, uncleared count below the top advances by exactly one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && count != TOP) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/zcg_ctrl.sv
module zcg_ctrl
    import zcg_pkg::*;
#(
    parameter int GAIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [GAIN_W-1:0] req_gain,
    input  logic              zc_en,
    input  logic              zc_hit,
    input  logic              tmo_fire,
    output logic              tmo_clear,
    output logic              waiting,
    output logic [GAIN_W-1:0] gain_q
);
    zcg_state_e        state, state_nx;
    logic [GAIN_W-1:0] held_q;
    logic [GAIN_W-1:0] gain_nx, held_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and data
    always_comb begin
        state_nx = state;
        gain_nx  = gain_q;
        held_nx  = held_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!zc_en) begin          // T_DIRECT
                        gain_nx = req_gain;
                    end else begin             // T_ARM
                        held_nx  = req_gain;
                        state_nx = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!zc_en) begin              // T_BYPASS
                    gain_nx  = req_valid ? req_gain : held_q;
                    state_nx = ST_IDLE;
                end else if (req_valid) begin  // T_REARM
                    held_nx = req_gain;
                end else if (zc_hit || tmo_fire) begin // T_ZC / T_TIMEOUT
                    gain_nx  = held_q;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // output and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '1;
            held_q <= '1;
        end else begin
            gain_q <= gain_nx;
            held_q <= held_nx;
        end
    end

    assign waiting   = (state == ST_WAIT);
    assign tmo_clear = (state != ST_WAIT) || (req_valid && zc_en);

    // R2: ungated request from idle lands on the next edge
    assert_direct_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && !zc_en) |=> (gain_q == $past(req_gain) && state == ST_IDLE));

    // R3: a quiet gated wait keeps the output steady
    assert_hold_while_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && zc_en && !req_valid && !zc_hit && !tmo_fire) |=> ($stable(gain_q) && state == ST_WAIT));

    // R9: arming ignores a same-cycle crossing
    assert_arm_ignores_zc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && zc_en) |=> (state == ST_WAIT && $stable(gain_q)));

    // R8: gating off during a wait ends it
    assert_bypass_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !zc_en) |=> state == ST_IDLE);
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater #(
    parameter int GAIN_W      = 8,
    parameter int SAMPLE_W    = 16,
    parameter int TIMEOUT_W   = 17,
    parameter int NEAR_THRESH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [GAIN_W-1:0]          req_gain,
    input  logic                       zc_en,
    input  logic                       timeout_dis,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic [GAIN_W-1:0]          gain_out,
    output logic                       pending
);
    logic zc_hit;
    logic tmo_fire;
    logic tmo_clear;
    logic waiting;

    zcg_crossing_detect #(
        .SAMPLE_W   (SAMPLE_W),
        .NEAR_THRESH(NEAR_THRESH)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .sample      (sample),
        .zc_hit      (zc_hit)
    );

    zcg_timeout #(
        .TIMEOUT_W(TIMEOUT_W)
    ) u_timeout (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(tmo_clear),
        .run  (waiting && !timeout_dis),
        .fire (tmo_fire)
    );

    zcg_ctrl #(
        .GAIN_W(GAIN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_gain (req_gain),
        .zc_en    (zc_en),
        .zc_hit   (zc_hit),
        .tmo_fire (tmo_fire),
        .tmo_clear(tmo_clear),
        .waiting  (waiting),
        .gain_q   (gain_out)
    );

    assign pending = waiting;

    // R6: timeout disabled and nothing else happening means the wait persists
    assert_no_forced_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && timeout_dis && zc_en && !req_valid && !zc_hit) |=> pending);

    // R1: first cycle out of reset is idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pending && gain_out == '1));
endmodule

// File: tb/zc_gain_updater_tb_top.sv
module zc_gain_updater_tb_top;
    localparam int GW  = 8;
    localparam int SW  = 16;
    localparam int TW  = 6;
    localparam int THR = 4;
    localparam int TOP = (1 << TW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic [GW-1:0]        req_gain = '0;
    logic                 zc_en = 1'b0;
    logic                 timeout_dis = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample = '0;
    logic [GW-1:0]        gain_out;
    logic                 pending;

    always #5 clk = ~clk;

    zc_gain_updater #(
        .GAIN_W(GW), .SAMPLE_W(SW), .TIMEOUT_W(TW), .NEAR_THRESH(THR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gain(req_gain),
        .zc_en(zc_en), .timeout_dis(timeout_dis), .sample_valid(sample_valid),
        .sample(sample), .gain_out(gain_out), .pending(pending)
    );

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    logic [GW-1:0] m_gain, m_held;
    logic          m_pend, m_pv, m_psign;
    int            m_cnt;
    string         m_tag;

    function automatic logic is_crossing(logic sv, logic signed [SW-1:0] s, logic pv, logic ps);
        if (!sv) return 1'b0;                                  // R10
        if (int'(s) > -THR && int'(s) < THR) return 1'b1;      // R4 magnitude
        return pv && (ps != s[SW-1]);                          // R4 sign change
    endfunction

    task automatic model_step();
        logic zc;
        zc = is_crossing(sample_valid, sample, m_pv, m_psign);
        if (!m_pend) begin
            if (req_valid && !zc_en) begin m_gain = req_gain; m_tag = "R2"; end
            else if (req_valid) begin m_held = req_gain; m_pend = 1; m_cnt = 0; m_tag = zc ? "R9" : "R3"; end
            else m_tag = "R3";
        end else begin
            if (!zc_en) begin m_gain = req_valid ? req_gain : m_held; m_pend = 0; m_tag = "R8"; end
            else if (req_valid) begin m_held = req_gain; m_cnt = 0; m_tag = "R7"; end
            else if (zc) begin m_gain = m_held; m_pend = 0; m_tag = sample_valid ? "R4" : "R10"; end
            else if (!timeout_dis && m_cnt == TOP) begin m_gain = m_held; m_pend = 0; m_tag = "R5"; end
            else begin
                if (!timeout_dis) m_cnt++;
                m_tag = timeout_dis ? "R6" : (sample_valid ? "R5" : "R10");
            end
        end
        if (sample_valid) begin m_pv = 1; m_psign = sample[SW-1]; end
    endtask

    task automatic check_out();
        n_vec++;
        if (gain_out !== m_gain || pending !== m_pend) begin
            n_bad++;
            $display("FAIL %s: gain=%0h pending=%0b expected gain=%0h pending=%0b",
                     m_tag, gain_out, pending, m_gain, m_pend);
        end
    endtask

    task automatic cycle(logic rv, logic [GW-1:0] g, logic en, logic td,
                         logic sv, logic signed [SW-1:0] s);
        req_valid = rv; req_gain = g; zc_en = en; timeout_dis = td;
        sample_valid = sv; sample = s;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_out();
    endtask

    localparam logic signed [SW-1:0] BIGP = 16'sd1000;
    localparam logic signed [SW-1:0] BIGN = -16'sd1000;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        m_gain = '1; m_held = '1; m_pend = 0; m_pv = 0; m_psign = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_tag = "R1";
        check_out();                                        // R1 reset state

        cycle(1, 8'h40, 0, 0, 0, BIGP);                     // R2 direct
        cycle(1, 8'h22, 1, 0, 1, 16'sd0);                   // R9 arm with zero sample
        for (int i = 0; i < 5; i++) cycle(0, 8'h00, 1, 0, 1, BIGP); // R3 hold (first sample +)
        cycle(0, 8'h00, 1, 0, 1, BIGN);                     // R4 sign change applies 22
        cycle(1, 8'h33, 1, 0, 1, BIGN);                     // arm
        cycle(0, 8'h00, 1, 0, 1, -16'sd3);                  // R4 near zero
        cycle(1, 8'h44, 1, 0, 0, BIGN);                     // arm
        cycle(0, 8'h00, 1, 0, 0, BIGP);                     // R10 invalid flip ignored
        cycle(0, 8'h00, 1, 0, 1, BIGN);                     // prev still negative: no cross
        for (int i = 0; i < TOP; i++) cycle(0, 8'h00, 1, 0, 1, BIGN); // R5 reaches top
        cycle(1, 8'h55, 1, 0, 1, BIGN);                     // arm
        for (int i = 0; i < 20; i++) cycle(0, 8'h00, 1, 0, 1, BIGN);
        cycle(1, 8'h66, 1, 0, 1, BIGP);                     // R7 rearm ignores flip
        for (int i = 0; i < TOP + 1; i++) cycle(0, 8'h00, 1, 0, 1, BIGP); // R7 restart timing
        cycle(1, 8'h77, 1, 1, 1, BIGP);                     // arm, timeout off
        for (int i = 0; i < 3 * TOP; i++) cycle(0, 8'h00, 1, 1, 1, BIGP); // R6 no force
        cycle(0, 8'h00, 1, 0, 1, BIGP);                     // R6 resume count
        cycle(0, 8'h00, 0, 0, 1, BIGP);                     // R8 bypass with held
        cycle(1, 8'h12, 1, 0, 1, BIGP);                     // arm
        cycle(1, 8'h34, 0, 0, 1, BIGP);                     // R8 bypass with new request

        for (int i = 0; i < 6000; i++) begin : rnd
            logic signed [SW-1:0] s;
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0)      s = SW'($signed(int'($urandom_range(0, 10)) - 5));
            else if (m_psign)     s = (r[7:4] == 0) ? BIGP : BIGN;
            else                  s = (r[7:4] == 0) ? BIGN : BIGP;
            cycle(r[12:10] == 0, GW'($urandom), r[15:13] != 0, r[19:16] == 0,
                  r[21:20] != 0, s);
        end

        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_gain = '1; m_held = '1; m_pend = 0; m_pv = 0; m_psign = 0; m_cnt = 0; m_tag = "R1";
        check_out();                                        // R1 after mid-run reset

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule